// File: doc/BRIEF.md
# Video Field Error-Check CRC Engine

This block checks and rebuilds the per-field error-detection CRCs that a serial digital video link carries in its error-check packet. It covers two regions of each field: the full field and the active picture. For each region it runs two CRC accumulators. One runs over the words that arrive at the block, and the other runs over the words that leave it. The outgoing words may differ from the incoming ones when the video path clips values or rewrites timing codes. Because the inserted CRC is always taken from the outgoing accumulator, it describes the stream that is actually sent.

At the field-end strobe, the block samples the CRCs, validity bits and error flags decoded from the received packet. A received CRC marked valid is compared with the incoming calculation. A received CRC marked invalid is not compared. Instead, that region reports an unknown-error status, and its outgoing validity bit is driven high so that downstream equipment can check the freshly computed CRC. The flags, the outgoing CRCs and copies of the received values stay stable on plain register outputs until the next field end. Packet parsing, packet insertion and host registers are handled by neighbouring blocks.

Top module: `edh_crc_engine`

## Requirements
- R1: Each accumulator is a 16-bit CRC with polynomial x^16+x^12+x^5+1 (0x1021).
  - It takes one 10-bit word on each cycle in which its region enable is high.
  - Word bits are fed least significant first. For each bit, feedback = crc[15] XOR bit, then crc shifts left by one; if feedback is 1, crc is XORed with 0x1021.
  - In the first enabled cycle after a cycle with the enable low, the accumulator starts from zero instead of its previous value.
- R2: The full-field accumulators use `ff_en` and the active-picture accumulators use `ap_en`. The incoming pair works on `in_word` and the outgoing pair on `out_word`. `tx_ff_crc` and `tx_ap_crc` come from the outgoing pair only.
- R3: If a region's received validity bit is 1 at field end, that region's error flag is 1 exactly when the received CRC differs from the incoming calculation.
- R4: If a region's received validity bit is 0 at field end, that region's error flag is 0 and its unknown-error status is 1. Otherwise the status is 0.
- R5: A region's `*_eda` output is the OR of that region's received EDA and EDH flags, whatever the validity bit.
- R6: A region's outgoing validity bit is 1 unless its `force_*v_low` input is 1 at field end, in which case it is 0. The received validity bit has no effect on it.
- R7: `stat_rx_ff_crc`, `stat_rx_ap_crc`, `stat_rx_ffv` and `stat_rx_apv` show the received CRCs and validity bits as sampled at field end.
- R8: All outputs are loaded on the clock edge at which `field_end` is 1, and they hold in every other cycle.
  - The calculations that are loaded include a word enabled in that same cycle.
- R9: After reset, the CRC outputs, error flags, status bits and copies of received values are 0, and both outgoing validity bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 10 | Word entering the video path |
| out_word | input | 10 | Word leaving the video path |
| ff_en | input | 1 | Full-field region enable |
| ap_en | input | 1 | Active-picture region enable |
| field_end | input | 1 | Field-end strobe; latches all results |
| rx_ff_crc | input | 16 | Received full-field CRC |
| rx_ap_crc | input | 16 | Received active-picture CRC |
| rx_ffv | input | 1 | Received full-field validity bit |
| rx_apv | input | 1 | Received active-picture validity bit |
| rx_ff_edh | input | 1 | Received full-field EDH flag |
| rx_ff_eda | input | 1 | Received full-field EDA flag |
| rx_ap_edh | input | 1 | Received active-picture EDH flag |
| rx_ap_eda | input | 1 | Received active-picture EDA flag |
| force_ffv_low | input | 1 | Override that clears the outgoing full-field validity bit |
| force_apv_low | input | 1 | Override that clears the outgoing active-picture validity bit |
| tx_ff_crc | output | 16 | Outgoing full-field CRC for insertion |
| tx_ap_crc | output | 16 | Outgoing active-picture CRC for insertion |
| tx_ffv | output | 1 | Outgoing full-field validity bit |
| tx_apv | output | 1 | Outgoing active-picture validity bit |
| ff_edh_err | output | 1 | Full-field CRC mismatch flag |
| ap_edh_err | output | 1 | Active-picture CRC mismatch flag |
| ff_eda | output | 1 | Full-field error-detected-already flag |
| ap_eda | output | 1 | Active-picture error-detected-already flag |
| ff_ues | output | 1 | Full-field unknown-error status |
| ap_ues | output | 1 | Active-picture unknown-error status |
| stat_rx_ff_crc | output | 16 | Received full-field CRC as sampled |
| stat_rx_ap_crc | output | 16 | Received active-picture CRC as sampled |
| stat_rx_ffv | output | 1 | Received full-field validity bit as sampled |
| stat_rx_apv | output | 1 | Received active-picture validity bit as sampled |

## Verification
Two things can happen in the same cycle: the field-end latch and the last word of a region. In that case the word must be folded into the CRC before the result is judged. The bench provokes this in two ways. Some fields raise `field_end` together with the final enabled word. Other fields raise it one idle cycle later. The expected CRCs, error flags and unknown-error status are computed in the bench over every enabled word in both cases, so a latch that uses the stale accumulator value shows up as a CRC or flag mismatch. A third kind of overlap is a region window restarting right after the previous field. The one-cycle idle gap between fields exercises the preset to zero.

// File: rtl/edh_crc_pkg.sv
package edh_crc_pkg;
  localparam int WORD_W_DEF = 10;
  localparam int CRC_W_DEF  = 16;
  localparam int N_REG      = 2;
  localparam int REG_FF     = 0;
  localparam int REG_AP     = 1;

  typedef struct packed {
    logic edh;
    logic eda;
    logic ues;
    logic txv;
    logic rxv;
  } region_flags_t;
endpackage

// File: rtl/edh_crc_accum.sv
module edh_crc_accum #(
  parameter int                WORD_W = 10,
  parameter int                CRC_W  = 16,
  parameter logic [CRC_W-1:0]  POLY   = 'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc_nx
);
  logic [CRC_W-1:0] crc_q;
  logic             en_d;
  logic [CRC_W-1:0] seed;

  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c,
                                            input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[CRC_W-1] ^ w[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  // Window start: the accumulator restarts from zero.
  always_comb begin
    seed   = (en && !en_d) ? '0 : crc_q;
    crc_nx = en ? step(seed, word) : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      en_d  <= 1'b0;
    end else begin
      crc_q <= crc_nx;
      en_d  <= en;
    end
  end
endmodule

// File: rtl/edh_region_judge.sv
module edh_region_judge
  import edh_crc_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch,
  input  logic [CRC_W-1:0] calc_in,
  input  logic [CRC_W-1:0] calc_out,
  input  logic [CRC_W-1:0] rx_crc,
  input  logic             rx_v,
  input  logic             rx_edh,
  input  logic             rx_eda,
  input  logic             force_low,
  output region_flags_t    flags,
  output logic [CRC_W-1:0] tx_crc,
  output logic [CRC_W-1:0] st_rx_crc
);
  region_flags_t    flags_nx;
  logic [CRC_W-1:0] tx_crc_nx;
  logic [CRC_W-1:0] st_rx_crc_nx;

  always_comb begin
    flags_nx     = flags;
    tx_crc_nx    = tx_crc;
    st_rx_crc_nx = st_rx_crc;
    if (latch) begin
      flags_nx.edh = rx_v && (rx_crc != calc_in);
      flags_nx.ues = !rx_v;
      flags_nx.eda = rx_eda | rx_edh;
      flags_nx.txv = !force_low;
      flags_nx.rxv = rx_v;
      tx_crc_nx    = calc_out;
      st_rx_crc_nx = rx_crc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '{edh: 1'b0, eda: 1'b0, ues: 1'b0, txv: 1'b1, rxv: 1'b0};
      tx_crc    <= '0;
      st_rx_crc <= '0;
    end else begin
      flags     <= flags_nx;
      tx_crc    <= tx_crc_nx;
      st_rx_crc <= st_rx_crc_nx;
    end
  end
endmodule

// File: rtl/edh_crc_engine.sv
module edh_crc_engine
  import edh_crc_pkg::*;
#(
  parameter int               WORD_W = WORD_W_DEF,
  parameter int               CRC_W  = CRC_W_DEF,
  parameter logic [CRC_W-1:0] POLY   = 'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic [WORD_W-1:0] out_word,
  input  logic              ff_en,
  input  logic              ap_en,
  input  logic              field_end,
  input  logic [CRC_W-1:0]  rx_ff_crc,
  input  logic [CRC_W-1:0]  rx_ap_crc,
  input  logic              rx_ffv,
  input  logic              rx_apv,
  input  logic              rx_ff_edh,
  input  logic              rx_ff_eda,
  input  logic              rx_ap_edh,
  input  logic              rx_ap_eda,
  input  logic              force_ffv_low,
  input  logic              force_apv_low,
  output logic [CRC_W-1:0]  tx_ff_crc,
  output logic [CRC_W-1:0]  tx_ap_crc,
  output logic              tx_ffv,
  output logic              tx_apv,
  output logic              ff_edh_err,
  output logic              ap_edh_err,
  output logic              ff_eda,
  output logic              ap_eda,
  output logic              ff_ues,
  output logic              ap_ues,
  output logic [CRC_W-1:0]  stat_rx_ff_crc,
  output logic [CRC_W-1:0]  stat_rx_ap_crc,
  output logic              stat_rx_ffv,
  output logic              stat_rx_apv
);
  logic [N_REG-1:0] reg_en;
  logic [N_REG-1:0] rx_v_a, rx_edh_a, rx_eda_a, force_a;
  logic [CRC_W-1:0] rx_crc_a   [N_REG];
  logic [CRC_W-1:0] calc_in_a  [N_REG];
  logic [CRC_W-1:0] calc_out_a [N_REG];
  logic [CRC_W-1:0] tx_crc_a   [N_REG];
  logic [CRC_W-1:0] st_crc_a   [N_REG];
  region_flags_t    flags_a    [N_REG];

  assign reg_en[REG_FF]   = ff_en;
  assign reg_en[REG_AP]   = ap_en;
  assign rx_v_a[REG_FF]   = rx_ffv;
  assign rx_v_a[REG_AP]   = rx_apv;
  assign rx_edh_a[REG_FF] = rx_ff_edh;
  assign rx_edh_a[REG_AP] = rx_ap_edh;
  assign rx_eda_a[REG_FF] = rx_ff_eda;
  assign rx_eda_a[REG_AP] = rx_ap_eda;
  assign force_a[REG_FF]  = force_ffv_low;
  assign force_a[REG_AP]  = force_apv_low;
  assign rx_crc_a[REG_FF] = rx_ff_crc;
  assign rx_crc_a[REG_AP] = rx_ap_crc;

  for (genvar g = 0; g < N_REG; g++) begin : g_region
    edh_crc_accum #(.WORD_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) u_acc_in (
      .clk(clk), .rst_n(rst_n), .en(reg_en[g]), .word(in_word),
      .crc_nx(calc_in_a[g]));
    edh_crc_accum #(.WORD_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) u_acc_out (
      .clk(clk), .rst_n(rst_n), .en(reg_en[g]), .word(out_word),
      .crc_nx(calc_out_a[g]));
    edh_region_judge #(.CRC_W(CRC_W)) u_judge (
      .clk(clk), .rst_n(rst_n), .latch(field_end),
      .calc_in(calc_in_a[g]), .calc_out(calc_out_a[g]),
      .rx_crc(rx_crc_a[g]), .rx_v(rx_v_a[g]), .rx_edh(rx_edh_a[g]),
      .rx_eda(rx_eda_a[g]), .force_low(force_a[g]),
      .flags(flags_a[g]), .tx_crc(tx_crc_a[g]), .st_rx_crc(st_crc_a[g]));
  end

  assign tx_ff_crc      = tx_crc_a[REG_FF];
  assign tx_ap_crc      = tx_crc_a[REG_AP];
  assign stat_rx_ff_crc = st_crc_a[REG_FF];
  assign stat_rx_ap_crc = st_crc_a[REG_AP];
  assign tx_ffv         = flags_a[REG_FF].txv;
  assign tx_apv         = flags_a[REG_AP].txv;
  assign ff_edh_err     = flags_a[REG_FF].edh;
  assign ap_edh_err     = flags_a[REG_AP].edh;
  assign ff_eda         = flags_a[REG_FF].eda;
  assign ap_eda         = flags_a[REG_AP].eda;
  assign ff_ues         = flags_a[REG_FF].ues;
  assign ap_ues         = flags_a[REG_AP].ues;
  assign stat_rx_ffv    = flags_a[REG_FF].rxv;
  assign stat_rx_apv    = flags_a[REG_AP].rxv;
endmodule

// File: rtl/edh_crc_engine_chk.sv
module edh_crc_engine_chk #(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             field_end,
  input logic [CRC_W-1:0] rx_ff_crc,
  input logic             rx_ffv,
  input logic             rx_apv,
  input logic             rx_ff_edh,
  input logic             rx_ff_eda,
  input logic             rx_ap_edh,
  input logic             rx_ap_eda,
  input logic             force_ffv_low,
  input logic             force_apv_low,
  input logic [CRC_W-1:0] tx_ff_crc,
  input logic [CRC_W-1:0] tx_ap_crc,
  input logic             tx_ffv,
  input logic             tx_apv,
  input logic             ff_edh_err,
  input logic             ap_edh_err,
  input logic             ff_eda,
  input logic             ap_eda,
  input logic             ff_ues,
  input logic             ap_ues,
  input logic [CRC_W-1:0] stat_rx_ff_crc
);
  p_ff_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !rx_ffv) |=> (!ff_edh_err && ff_ues));
  p_ap_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !rx_apv) |=> (!ap_edh_err && ap_ues));
  p_ff_eda_r5: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (ff_eda == $past(rx_ff_eda | rx_ff_edh)));
  p_ap_eda_r5: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (ap_eda == $past(rx_ap_eda | rx_ap_edh)));
  p_txv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> ((tx_ffv == !$past(force_ffv_low)) && (tx_apv == !$past(force_apv_low))));
  p_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (stat_rx_ff_crc == $past(rx_ff_crc)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> ($stable(tx_ff_crc) && $stable(tx_ap_crc) && $stable(ff_edh_err)
                    && $stable(ap_edh_err) && $stable(ff_ues) && $stable(ap_ues)
                    && $stable(tx_ffv) && $stable(tx_apv)));
endmodule

bind edh_crc_engine edh_crc_engine_chk #(.CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_end(field_end), .rx_ff_crc(rx_ff_crc),
  .rx_ffv(rx_ffv), .rx_apv(rx_apv), .rx_ff_edh(rx_ff_edh), .rx_ff_eda(rx_ff_eda),
  .rx_ap_edh(rx_ap_edh), .rx_ap_eda(rx_ap_eda), .force_ffv_low(force_ffv_low),
  .force_apv_low(force_apv_low), .tx_ff_crc(tx_ff_crc), .tx_ap_crc(tx_ap_crc),
  .tx_ffv(tx_ffv), .tx_apv(tx_apv), .ff_edh_err(ff_edh_err), .ap_edh_err(ap_edh_err),
  .ff_eda(ff_eda), .ap_eda(ap_eda), .ff_ues(ff_ues), .ap_ues(ap_ues),
  .stat_rx_ff_crc(stat_rx_ff_crc));

// File: tb/tb_edh_crc_engine.sv
module tb_edh_crc_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  in_word, out_word;
  logic        ff_en, ap_en, field_end;
  logic [15:0] rx_ff_crc, rx_ap_crc;
  logic        rx_ffv, rx_apv, rx_ff_edh, rx_ff_eda, rx_ap_edh, rx_ap_eda;
  logic        force_ffv_low, force_apv_low;
  logic [15:0] tx_ff_crc, tx_ap_crc, stat_rx_ff_crc, stat_rx_ap_crc;
  logic        tx_ffv, tx_apv, ff_edh_err, ap_edh_err, ff_eda, ap_eda, ff_ues, ap_ues;
  logic        stat_rx_ffv, stat_rx_apv;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  edh_crc_engine dut (.*);

  function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [9:0] w);
    logic [15:0] r = c;
    for (int i = 0; i < 10; i++) begin
      logic fb = r[15] ^ w[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One field: an idle cycle, then n words with ff_en, ap_en inside [a0,a1].
  task automatic do_field(input int n, input bit coin, input bit modify,
                          input bit ffv, input bit apv, input bit ffbad, input bit apbad,
                          input bit fff, input bit apf, input logic [3:0] rxflags);
    logic [15:0] ci_ff = 0, ci_ap = 0, co_ff = 0, co_ap = 0;
    logic [15:0] rff, rap;
    int a0 = 1 + int'($urandom_range(0, n / 3));
    int a1 = n - 2 - int'($urandom_range(0, n / 3));
    @(negedge clk);
    ff_en = 0; ap_en = 0; field_end = 0;
    for (int i = 0; i < n; i++) begin
      logic [9:0] wi = 10'($urandom);
      logic [9:0] wo = (modify && ($urandom_range(0, 3) == 0)) ? 10'($urandom) : wi;
      @(negedge clk);
      in_word = wi; out_word = wo; ff_en = 1;
      ap_en = (i >= a0) && (i <= a1);
      ci_ff = crc_word(ci_ff, wi); co_ff = crc_word(co_ff, wo);
      if (ap_en) begin ci_ap = crc_word(ci_ap, wi); co_ap = crc_word(co_ap, wo); end
      field_end = coin && (i == n - 1);
    end
    if (!coin) begin
      @(negedge clk);
      ff_en = 0; ap_en = 0; field_end = 1;
    end
    rff = ffbad ? ci_ff ^ 16'(1 + $urandom_range(0, 16'hfffe)) : ci_ff;
    rap = apbad ? ci_ap ^ 16'(1 + $urandom_range(0, 16'hfffe)) : ci_ap;
    rx_ff_crc = rff; rx_ap_crc = rap; rx_ffv = ffv; rx_apv = apv;
    {rx_ff_edh, rx_ff_eda, rx_ap_edh, rx_ap_eda} = rxflags;
    force_ffv_low = fff; force_apv_low = apf;
    @(negedge clk);
    field_end = 0; ff_en = 0; ap_en = 0;
    // R1 R2 R8: outgoing CRCs include any word of the field_end cycle
    chk("R1/R8 tx_ff_crc", tx_ff_crc, co_ff);
    chk("R2 tx_ap_crc", tx_ap_crc, co_ap);
    chk("R3 ff_edh_err", ff_edh_err, ffv && ffbad);
    chk("R3 ap_edh_err", ap_edh_err, apv && apbad);
    chk("R4 ff_ues", ff_ues, !ffv);
    chk("R4 ap_ues", ap_ues, !apv);
    chk("R5 ff_eda", ff_eda, rxflags[3] | rxflags[2]);
    chk("R5 ap_eda", ap_eda, rxflags[1] | rxflags[0]);
    chk("R6 tx_ffv", tx_ffv, !fff);
    chk("R6 tx_apv", tx_apv, !apf);
    chk("R7 stat_rx_ff_crc", stat_rx_ff_crc, rff);
    chk("R7 stat_rx_ap_crc", stat_rx_ap_crc, rap);
    chk("R7 stat_rx_v", {stat_rx_ffv, stat_rx_apv}, {ffv, apv});
    // R8: inputs move without field_end, outputs hold
    rx_ff_crc = ~rff; rx_ffv = !ffv; rx_apv = !apv; force_ffv_low = !fff;
    rx_ff_eda = ~rx_ff_eda; in_word = ~in_word;
    repeat (2) @(negedge clk);
    chk("R8 hold tx_ff_crc", tx_ff_crc, co_ff);
    chk("R8 hold flags", {ff_edh_err, ff_ues, tx_ffv, ff_eda},
        {ffv && ffbad, !ffv, !fff, rxflags[3] | rxflags[2]});
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; in_word = 0; out_word = 0; ff_en = 0; ap_en = 0; field_end = 0;
    rx_ff_crc = 0; rx_ap_crc = 0; rx_ffv = 0; rx_apv = 0;
    rx_ff_edh = 0; rx_ff_eda = 0; rx_ap_edh = 0; rx_ap_eda = 0;
    force_ffv_low = 0; force_apv_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset crcs", {tx_ff_crc, tx_ap_crc}, 32'h0);
    chk("R9 reset flags", {ff_edh_err, ap_edh_err, ff_ues, ap_ues, ff_eda, ap_eda}, 6'b0);
    chk("R9 reset validity", {tx_ffv, tx_apv, stat_rx_ffv, stat_rx_apv}, 4'b1100);
    // directed corners
    do_field(12, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000);
    do_field(12, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0101);
    do_field(16, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1010);
    do_field(9,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1111);
    // constrained random
    for (int k = 0; k < 40; k++)
      do_field(8 + int'($urandom_range(0, 40)), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, 4'($urandom));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule